// File: doc/BRIEF.md
# Channel Microcode Loop Sequencer

This block is a single channel thread of a programmable DMA engine. It holds a
byte-coded program in a small local instruction memory and steps through it one
byte per clock. The instructions it runs can set the channel control word and
the destination address, open and close two nested hardware loops, emit a
zero-fill store beat, do nothing, or end the thread. Every zero-fill beat is
presented on a valid/ready request port. The beat carries the current
destination address and the burst shape taken from the control word.

Software writes the program through a byte-wide write port while the thread is
stopped. It then pulses `start` with the program's byte address. The thread
reports its condition on a 4-bit state code. It returns to stopped after the
end instruction. An unknown opcode leaves it in a faulting state until reset.

Top module: `ucode_loop_seq`

## Requirements
- R1: While reset is high (synchronous, active high), and after it, the state code is 0x0 (stopped) and `stz_valid` is low.
- R2: A `start` pulse is taken only in the stopped state, and fetch then begins at `start_pc`. A `start` pulse seen while executing or faulting has no effect.
- R3: Fetch consumes one program byte per cycle. An instruction whose first byte lies k bytes after `start_pc`, reached with no branch or stall on the way, is acted on in the (k+2)-th cycle after the start edge. A zero-fill request there becomes visible on the port after that edge.
- R4: Opcode 0xBC is a 6-byte register move. Byte 1 selects the target: 0 is the source address, which is accepted but unused; 1 is the control word; 2 is the destination address. Bytes 2..5 give the 32-bit value, least significant byte first. In the control word, bits 21:18 hold burst length minus one, bits 17:15 hold log2 of the beat size in bytes, and bit 14 enables destination increment.
- R5: Opcode 0x0C (1 byte) raises `stz_valid` with `stz_addr` equal to the destination address, and with `stz_blen`/`stz_bsize` taken from control bits 21:18 and 17:15. The request holds steady until `stz_ready`. On acceptance, and when bit 14 is set, the destination address advances by (burst length minus one, plus one) times 2^size bytes. Otherwise it is unchanged. The address is kept across runs.
- R6: Opcode 0x20 (counter 0) or 0x22 (counter 1) is a 2-byte loop start whose byte 1 is the iteration count minus one, so 256 iterations encode as 255. Opcode 0x38 (counter 0) or 0x3C (counter 1) is a 2-byte loop end whose byte 1 is the distance back from its own first byte to the first byte after the matching loop start. When the counter is non-zero, a loop end decrements it and branches. Otherwise it falls through. Two nested loops of n0 and n1 iterations around one zero-fill beat give n0*n1 beats.
- R7: Opcode 0x18 is a 1-byte no-op that costs exactly one fetch cycle.
- R8: Opcode 0x00 ends the thread. The state code is 0x9 (completing) for exactly one cycle and then 0x0.
- R9: Any other first opcode byte, or a move whose target byte is above 2, sets the state code to 0xF (faulting). Fetch then stops, no further request is raised, and the state holds until reset.
- R10: The state code is only ever 0x0, 0x1 (executing), 0x9 or 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | IMEM_AW | Program memory byte address |
| prog_data | input | 8 | Program byte to write |
| start | input | 1 | Start pulse, honoured only when stopped |
| start_pc | input | IMEM_AW | Byte address of the first instruction |
| stz_valid | output | 1 | Zero-fill beat request |
| stz_ready | input | 1 | Zero-fill beat accepted |
| stz_addr | output | ADDR_W | Destination address of the beat |
| stz_blen | output | 4 | Burst length minus one |
| stz_bsize | output | 3 | log2 of beat size in bytes |
| state | output | 4 | Thread state code |

## Verification
A wrong loop counter or branch offset shows at the ports as a beat count other
than n0*n1 once the thread stops. A broken byte count in the fetch stepper
moves the cycle of the first request away from k+2 and is caught within that
same run. A mistake in the destination stepping is caught on the very next
accepted beat, because every beat's address is compared with an arithmetic
prediction. A decoder that does not fault on an illegal byte shows within two
cycles as a state code other than 0xF.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_STOP  = 4'h0,
    ST_EXEC  = 4'h1,
    ST_DONE  = 4'h9,
    ST_FAULT = 4'hF
  } thr_state_e;

  localparam int NUM_LOOPS = 2;
  localparam int CNT_W     = 8;
  localparam int MAX_LEN   = 6;
  localparam int BUF_N     = MAX_LEN - 1;

  localparam logic [7:0] OP_END  = 8'h00;
  localparam logic [7:0] OP_STZ  = 8'h0C;
  localparam logic [7:0] OP_NOP  = 8'h18;
  localparam logic [7:0] OP_LP0  = 8'h20;
  localparam logic [7:0] OP_LP1  = 8'h22;
  localparam logic [7:0] OP_LPE0 = 8'h38;
  localparam logic [7:0] OP_LPE1 = 8'h3C;
  localparam logic [7:0] OP_MOV  = 8'hBC;

  // Instruction length in bytes; 0 marks an opcode outside the subset.
  function automatic logic [2:0] op_len(input logic [7:0] op);
    case (op)
      OP_END, OP_STZ, OP_NOP:        op_len = 3'd1;
      OP_LP0, OP_LP1,
      OP_LPE0, OP_LPE1:              op_len = 3'd2;
      OP_MOV:                        op_len = 3'd6;
      default:                       op_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_loop_ctr.sv
module seq_loop_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  // R6: a loop end only counts down a counter that still has passes left
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);

  // R6: loop start and loop end never hit the same counter in one cycle
  a_r6_load_dec_apart: assert property (@(posedge clk) disable iff (rst)
    !(load && dec));
endmodule

// File: rtl/ucode_loop_seq.sv
module ucode_loop_seq
  import seq_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [7:0]         prog_data,
  input  logic               start,
  input  logic [IMEM_AW-1:0] start_pc,
  output logic               stz_valid,
  input  logic               stz_ready,
  output logic [ADDR_W-1:0]  stz_addr,
  output logic [3:0]         stz_blen,
  output logic [2:0]         stz_bsize,
  output logic [3:0]         state
);
  localparam logic [IMEM_AW-1:0] PC_ONE = IMEM_AW'(1);

  thr_state_e               st;
  logic                     stz_pend;
  logic [IMEM_AW-1:0]       pc, iaddr, tgt;
  logic                     rv;
  logic [2:0]               bi;
  logic [BUF_N-1:0][7:0]    ibuf;
  logic [ADDR_W-1:0]        dar, step;
  logic                     dinc;
  logic [3:0]               blen;
  logic [2:0]               bsize;
  logic [7:0]               rdata, cur_op;
  logic [2:0]               cur_len;
  logic                     byte_in, last, bad, is_lpe, is_lp, taken;
  logic [31:0]              mov_val;
  logic [NUM_LOOPS-1:0]     ld, dec, dz;

  seq_imem #(.AW(IMEM_AW), .DW(8)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (rdata)
  );

  always_comb begin
    cur_op  = (bi == 3'd0) ? rdata : ibuf[0];
    cur_len = op_len(cur_op);
    byte_in = (st == ST_EXEC) && !stz_pend && rv;
    last    = byte_in && (cur_len != 3'd0) && ((bi + 3'd1) == cur_len);
    bad     = byte_in && (((bi == 3'd0) && (cur_len == 3'd0)) ||
              (last && (cur_op == OP_MOV) && (ibuf[1] > 8'd2)));
    is_lp   = last && ((cur_op == OP_LP0) || (cur_op == OP_LP1));
    is_lpe  = last && ((cur_op == OP_LPE0) || (cur_op == OP_LPE1));
    taken   = is_lpe && !dz[cur_op[2]];
    mov_val = {rdata, ibuf[4], ibuf[3], ibuf[2]};
    tgt     = iaddr - IMEM_AW'(rdata);
    step    = ADDR_W'({1'b0, blen} + 5'd1) << bsize;
  end

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    assign ld[g]  = is_lp  && (cur_op[1] == 1'(g));
    assign dec[g] = taken  && (cur_op[2] == 1'(g));
    seq_loop_ctr #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ld[g]),
      .load_val (rdata),
      .dec      (dec[g]),
      .zero     (dz[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_STOP;
      stz_pend <= 1'b0;
      pc       <= '0;
      iaddr    <= '0;
      rv       <= 1'b0;
      bi       <= '0;
      ibuf     <= '0;
      dar      <= '0;
      dinc     <= 1'b0;
      blen     <= '0;
      bsize    <= '0;
    end else begin
      case (st)
        ST_STOP: begin
          rv <= 1'b0;
          if (start) begin
            pc       <= start_pc;
            bi       <= '0;
            stz_pend <= 1'b0;
            st       <= ST_EXEC;
          end
        end
        ST_DONE:  st <= ST_STOP;
        ST_FAULT: st <= ST_FAULT;
        default: begin
          if (stz_pend) begin
            if (stz_ready) begin
              stz_pend <= 1'b0;
              if (dinc) dar <= dar + step;
            end
          end else begin
            pc <= pc + PC_ONE;
            rv <= 1'b1;
            if (byte_in) begin
              if (bi == 3'd0) iaddr <= pc - PC_ONE;
              if (bad) begin
                st <= ST_FAULT;
                rv <= 1'b0;
              end else if (last) begin
                bi <= '0;
                case (cur_op)
                  OP_END: begin
                    st <= ST_DONE;
                    rv <= 1'b0;
                  end
                  OP_STZ: begin
                    stz_pend <= 1'b1;
                    pc       <= pc;
                    rv       <= 1'b0;
                  end
                  OP_MOV: begin
                    if (ibuf[1] == 8'd1) begin
                      blen  <= mov_val[21:18];
                      bsize <= mov_val[17:15];
                      dinc  <= mov_val[14];
                    end else if (ibuf[1] == 8'd2) begin
                      dar <= ADDR_W'(mov_val);
                    end
                  end
                  default: begin
                    if (taken) begin
                      pc <= tgt;
                      rv <= 1'b0;
                    end
                  end
                endcase
              end else begin
                ibuf[bi] <= rdata;
                bi       <= bi + 3'd1;
              end
            end
          end
        end
      endcase
    end
  end

  assign state     = st;
  assign stz_valid = stz_pend;
  assign stz_addr  = dar;
  assign stz_blen  = blen;
  assign stz_bsize = bsize;

  // R10: only the four defined codes appear
  a_r10_state_code: assert property (@(posedge clk) disable iff (rst)
    (state == 4'h0) || (state == 4'h1) || (state == 4'h9) || (state == 4'hF));

  // R5: a pending beat holds address and shape until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (stz_valid && !stz_ready) |=> (stz_valid && $stable(stz_addr) &&
                                   $stable(stz_blen) && $stable(stz_bsize)));

  // R5: beats are raised only while the thread executes
  a_r5_req_in_exec: assert property (@(posedge clk) disable iff (rst)
    stz_valid |-> (state == 4'h1));

  // R8: completing lasts one cycle and leads to stopped
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == 4'h9) |=> (state == 4'h0));

  // R9: faulting is held until reset
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == 4'hF) |=> (state == 4'hF));
endmodule

// File: tb/test_ucode_loop_seq.sv
`timescale 1ns/1ps
module test_ucode_loop_seq;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          prog_we;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          start;
  logic [AW-1:0] start_pc;
  logic          stz_valid;
  logic          stz_ready;
  logic [31:0]   stz_addr;
  logic [3:0]    stz_blen;
  logic [2:0]    stz_bsize;
  logic [3:0]    state;

  always #2 clk = ~clk;

  ucode_loop_seq #(.IMEM_AW(AW), .ADDR_W(32)) i_ucode_loop_seq (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .start_pc(start_pc),
    .stz_valid(stz_valid), .stz_ready(stz_ready), .stz_addr(stz_addr),
    .stz_blen(stz_blen), .stz_bsize(stz_bsize), .state(state)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          beats = 0;
  int          rdy_mode = 0;
  int          cyc = 0;
  logic [31:0] exp_addr = '0;
  logic        exp_inc = 1'b0;
  logic [3:0]  exp_blen = '0;
  logic [2:0]  exp_bsize = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // Ready driver and beat checker
  initial begin
    stz_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      stz_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ((cyc % 3) != 0);
      if (stz_valid && stz_ready) begin
        beats++;
        chk(stz_addr == exp_addr, "R5 beat address", stz_addr, exp_addr);
        chk(stz_blen == exp_blen, "R4 burst length field", stz_blen, exp_blen);
        chk(stz_bsize == exp_bsize, "R4 burst size field", stz_bsize, exp_bsize);
        if (exp_inc) exp_addr = exp_addr + 32'((int'(exp_blen) + 1) << exp_bsize);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog act=running exp=stopped");
    finish_up();
  end

  task automatic wb(input int a, input logic [7:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a[AW-1:0]; prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic mov(inout int a, input logic [7:0] sel, input logic [31:0] v);
    wb(a, 8'hBC); wb(a + 1, sel);
    wb(a + 2, v[7:0]); wb(a + 3, v[15:8]); wb(a + 4, v[23:16]); wb(a + 5, v[31:24]);
    a = a + 6;
  endtask

  task automatic go(input int pc);
    @(negedge clk);
    start = 1'b1; start_pc = pc[AW-1:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stop();
    int n = 0;
    while (state != 4'h0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(state == 4'h0, "R8 thread stops after end", state, 0);
  endtask

  function automatic logic [31:0] ccr(input int bl, input int bs, input int inc);
    return 32'h8000_0001 | (32'(bl) << 18) | (32'(bs) << 15) | (32'(inc) << 14);
  endfunction

  task automatic set_exp(input int bl, input int bs, input int inc, input logic [31:0] base);
    exp_blen = bl[3:0]; exp_bsize = bs[2:0]; exp_inc = inc[0]; exp_addr = base;
  endtask

  task automatic build_loop(input int pb, input int n0, input int n1, input int bl,
                            input int bs, input int inc, input logic [31:0] base);
    int a = pb;
    mov(a, 8'd1, ccr(bl, bs, inc));
    mov(a, 8'd2, base);
    wb(pb + 12, 8'h22); wb(pb + 13, 8'(n1 - 1));
    wb(pb + 14, 8'h20); wb(pb + 15, 8'(n0 - 1));
    wb(pb + 16, 8'h0C);
    wb(pb + 17, 8'h38); wb(pb + 18, 8'd1);
    wb(pb + 19, 8'h3C); wb(pb + 20, 8'd5);
    wb(pb + 21, 8'h00);
  endtask

  task automatic loop_run(input int pb, input int n0, input int n1, input int bl,
                          input int bs, input int inc, input logic [31:0] base, input int rm);
    build_loop(pb, n0, n1, bl, bs, inc, base);
    set_exp(bl, bs, inc, base);
    beats = 0;
    rdy_mode = rm;
    go(pb);
    wait_stop();
    chk(beats == n0 * n1, "R6 nested loop beat count", beats, n0 * n1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(state == 4'h0, "R1 state in reset", state, 0);
    chk(stz_valid == 1'b0, "R1 no request in reset", stz_valid, 0);
    rst = 1'b0;
  endtask

  initial begin
    int a, k;
    rst = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    start = 1'b0; start_pc = '0;
    do_reset();
    @(negedge clk);
    chk(state == 4'h0, "R1 stopped after reset", state, 0);

    // R3: two moves then a store: request after 12+2 edges
    a = 8;
    mov(a, 8'd1, ccr(3, 2, 1));
    mov(a, 8'd2, 32'h0000_1000);
    wb(20, 8'h0C); wb(21, 8'h00);
    set_exp(3, 2, 1, 32'h0000_1000);
    beats = 0; rdy_mode = 0;
    go(8);
    k = 0;
    while (!stz_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == 14, "R3 first request cycle", k, 14);
    wait_stop();
    chk(beats == 1, "R5 single beat", beats, 1);

    // R7: two no-ops then a store; destination kept from last run (R5)
    wb(30, 8'h18); wb(31, 8'h18); wb(32, 8'h0C); wb(33, 8'h00);
    beats = 0;
    go(30);
    k = 0;
    while (!stz_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == 4, "R7 no-op costs one cycle", k, 4);
    chk(stz_addr == 32'h0000_1010, "R5 address kept across runs", stz_addr, 32'h1010);
    wait_stop();

    // R8: end alone: executing, completing for one cycle, stopped
    wb(40, 8'h00);
    go(40);
    @(negedge clk);
    chk(state == 4'h1, "R8 executing before end", state, 1);
    @(negedge clk);
    chk(state == 4'h9, "R8 completing", state, 9);
    @(negedge clk);
    chk(state == 4'h0, "R8 stopped after completing", state, 0);

    // R6 sweep over burst shapes, increment, loop counts and placement
    for (int bs = 0; bs < 4; bs++)
      for (int inc = 0; inc < 2; inc++)
        for (int i0 = 0; i0 < 2; i0++)
          for (int i1 = 0; i1 < 2; i1++) begin
            int n0 = (i0 == 0) ? 1 : 3;
            int n1 = (i1 == 0) ? 1 : 2;
            int bl = (bs * 5 + n0 * 3 + n1) % 16;
            int pb = ((bs * 8 + inc * 4 + i0 * 2 + i1) * 7) % 40;
            loop_run(pb, n0, n1, bl, bs, inc, 32'h0010_0000 + 32'(pb * 64), (bs + inc) % 2);
          end

    // R6: 256 iterations encode as 255
    loop_run(0, 256, 2, 15, 3, 1, 32'h0200_0000, 1);

    // R2: start while executing has no effect
    build_loop(0, 4, 1, 1, 0, 1, 32'h0000_4000);
    wb(60, 8'h00);
    set_exp(1, 0, 1, 32'h0000_4000);
    beats = 0; rdy_mode = 2;
    go(0);
    repeat (20) @(negedge clk);
    chk(stz_valid == 1'b1, "R5 request held while not ready", stz_valid, 1);
    go(60);
    rdy_mode = 0;
    wait_stop();
    chk(beats == 4, "R2 start ignored while executing", beats, 4);

    // R9: illegal opcode faults, holds, ignores start
    wb(50, 8'h55);
    beats = 0;
    go(50);
    @(negedge clk);
    @(negedge clk);
    chk(state == 4'hF, "R9 illegal opcode faults", state, 15);
    go(40);
    repeat (10) @(negedge clk);
    chk(state == 4'hF, "R9 fault held, R2 start ignored", state, 15);
    chk(beats == 0 && !stz_valid, "R9 no request after fault", beats, 0);
    do_reset();
    @(negedge clk);
    chk(state == 4'h0, "R1 reset clears fault", state, 0);

    // R9: move with target byte 3 faults
    a = 50;
    mov(a, 8'd3, 32'h1234_5678);
    go(50);
    repeat (10) @(negedge clk);
    chk(state == 4'hF, "R9 bad move target faults", state, 15);
    do_reset();

    finish_up();
  end
endmodule